// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block is a slave on a two-wire serial bus (I2C/SMBus style) that serves a 256-byte memory held in on-chip registers. A fast system clock samples the bus clock and data lines through synchronisers. The block pulls the data line low through an open-drain enable. A host can address the block, load a word address and write one byte or a burst of up to 16 bytes. It can also read from a loaded address or from the current address, and go on reading across the whole array.

Written bytes first collect in a 16-entry page buffer. They reach the array only when a STOP closes the write sequence. That STOP also starts a timed write cycle. During the cycle the slave refuses its own address, so a host can poll for completion. A write-protect input blocks every change to the array. Three strap inputs select one of eight bus addresses.

Top module: `twi_eeprom_slave`

## Requirements
- R1: A falling SDA while SCL is high (START) restarts address reception from any state, including in the middle of a byte. A rising SDA while SCL is high (STOP) returns the slave to idle with SDA released.
- R2: The slave acknowledges an address byte only when bits 7:4 equal 4'b1011 and bits 3:1 equal `strap_i`. It acknowledges by pulling SDA low during the ninth SCL clock. Bit 0 selects the direction: 1 means read, 0 means write. On any other address byte, SDA stays released until the next START.
- R3: In a write, the first byte after the address byte is the 8-bit word address. The slave acknowledges the word address and every later data byte on the ninth clock.
- R4: Each write data byte goes to the page buffer at the current address. After each byte the low 4 address bits increment and wrap within the same 16-byte page. The array changes only when a STOP ends the sequence.
- R5: A repeated START discards any buffered write data. The array is left unchanged and no write cycle starts.
- R6: While `wp_i` is high at the STOP, no byte of the array changes.
- R7: A STOP that ends a write sequence holding at least one data byte starts a write cycle lasting `WR_CYCLES` clocks. During the write cycle the slave does not acknowledge its address and keeps SDA released.
- R8: In a read, the slave shifts out each byte MSB first. The slave changes SDA only while SCL is low.
- R9: When the master acknowledges (SDA low on the ninth clock), the slave sends the byte at the next address. The address wraps from 255 to 0. When the master does not acknowledge, the slave releases SDA and stays quiet until a START or a STOP.
- R10: A read started without a word address begins at the address after the last one used. That is the address after the last byte read, or the address after the last byte written, wrapping within its page.
- R11: After reset, SDA is released, the address counter is 0 and every memory byte reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin (wired-AND level) |
| strap_i | input | 3 | Address strap, compared with address bits 3:1 |
| wp_i | input | 1 | Write protect: high blocks every array update |
| sda_pull_o | output | 1 | Open-drain enable: 1 pulls SDA low |

## Verification
Some properties are checked on every clock. The data-line enable may move only in the cycle after a detected SCL fall, START or STOP. A STOP always leaves SDA released. The array is committed only in a STOP cycle. A write cycle begins only from a commit, and SDA stays released while it runs.

Other behaviour appears only through whole bus transactions, which the bench's scenarios drive. These cover address and strap matching, word-address loading, page wrap inside the buffer, discarding the buffer on a repeated START, the effect of write protect, refusal of the address during the write cycle, sequential reads wrapping past address 255, and where a current-address read resumes.

// File: rtl/twi_eeprom_pkg.sv
package twi_eeprom_pkg;
  localparam int DATA_W  = 8;
  localparam int ADDR_W  = 8;
  localparam int PAGE_W  = 4;
  localparam int STRAP_W = 3;
  localparam logic [3:0] DEV_PREFIX = 4'b1011;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK_SET,
    ST_ACK_HOLD,
    ST_TX,
    ST_MACK
  } bus_st_t;

  typedef enum logic [1:0] {
    BK_DEV,
    BK_WADDR,
    BK_WDATA
  } byte_kind_t;

  // Address byte selects this slave: fixed prefix, strap match, not busy.
  function automatic logic dev_hit(input logic [DATA_W-1:0] b,
                                   input logic [STRAP_W-1:0] strap,
                                   input logic busy);
    return !busy && (b[7:4] == DEV_PREFIX) && (b[3:1] == strap);
  endfunction

  // Write pointer step: low bits roll within the page.
  function automatic logic [ADDR_W-1:0] page_step(input logic [ADDR_W-1:0] a);
    return {a[ADDR_W-1:PAGE_W], a[PAGE_W-1:0] + PAGE_W'(1)};
  endfunction

  // Read pointer step: whole counter rolls over.
  function automatic logic [ADDR_W-1:0] seq_step(input logic [ADDR_W-1:0] a);
    return a + ADDR_W'(1);
  endfunction
endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic [1:0] raw;
  logic [1:0] synced;
  logic [1:0] prev_q;
  logic       scl_s, scl_d, sda_d;

  assign raw = {scl_i, sda_i};

  genvar g;
  generate
    for (g = 0; g < 2; g++) begin : g_line
      logic [STAGES-1:0] sh_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '1;
        else        sh_q <= {sh_q[STAGES-2:0], raw[g]};
      end
      assign synced[g] = sh_q[STAGES-1];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '1;
    else        prev_q <= synced;
  end

  assign scl_s = synced[1];
  assign sda_s = synced[0];
  assign scl_d = prev_q[1];
  assign sda_d = prev_q[0];

  assign scl_rise = scl_s & ~scl_d;
  assign scl_fall = ~scl_s & scl_d;
  assign start_ev = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_ev  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/twi_proto_fsm.sv
module twi_proto_fsm
  import twi_eeprom_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       sda_s,
  input  logic                       scl_rise,
  input  logic                       scl_fall,
  input  logic                       start_ev,
  input  logic                       stop_ev,
  input  logic [STRAP_W-1:0]         strap,
  input  logic                       busy,
  input  logic                       buf_any,
  input  logic [DATA_W-1:0]          rd_data,
  output logic                       sda_pull,
  output logic                       buf_we,
  output logic [PAGE_W-1:0]          buf_idx,
  output logic [DATA_W-1:0]          buf_din,
  output logic                       buf_clr,
  output logic                       commit,
  output logic [ADDR_W-PAGE_W-1:0]   page_sel,
  output logic [ADDR_W-1:0]          rd_addr
);
  bus_st_t           state_q;
  byte_kind_t        kind_q;
  logic [3:0]        cnt_q;
  logic [DATA_W-2:0] shreg_q;
  logic [DATA_W-2:0] tx_q;
  logic [ADDR_W-1:0] addr_q;
  logic              rw_q;
  logic              pull_q;

  logic              byte_done;
  logic [DATA_W-1:0] rx_byte;

  assign rx_byte   = {shreg_q, sda_s};
  assign byte_done = (state_q == ST_RX) && scl_rise && (cnt_q == 4'd7);

  assign buf_we   = byte_done && (kind_q == BK_WDATA);
  assign buf_idx  = addr_q[PAGE_W-1:0];
  assign buf_din  = rx_byte;
  assign buf_clr  = start_ev;
  assign commit   = stop_ev && buf_any;
  assign page_sel = addr_q[ADDR_W-1:PAGE_W];
  assign rd_addr  = addr_q;
  assign sda_pull = pull_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      kind_q  <= BK_DEV;
      cnt_q   <= '0;
      shreg_q <= '0;
      tx_q    <= '0;
      addr_q  <= '0;
      rw_q    <= 1'b0;
      pull_q  <= 1'b0;
    end else if (start_ev) begin
      state_q <= ST_RX;
      kind_q  <= BK_DEV;
      cnt_q   <= '0;
      pull_q  <= 1'b0;
    end else if (stop_ev) begin
      state_q <= ST_IDLE;
      pull_q  <= 1'b0;
    end else begin
      unique case (state_q)
        ST_RX: begin
          if (scl_rise) begin
            shreg_q <= rx_byte[DATA_W-2:0];
            if (cnt_q == 4'd7) begin
              cnt_q <= '0;
              unique case (kind_q)
                BK_DEV: begin
                  if (dev_hit(rx_byte, strap, busy)) begin
                    rw_q    <= rx_byte[0];
                    state_q <= ST_ACK_SET;
                  end else begin
                    state_q <= ST_IDLE;
                  end
                end
                BK_WADDR: begin
                  addr_q  <= rx_byte;
                  state_q <= ST_ACK_SET;
                end
                default: begin
                  addr_q  <= page_step(addr_q);
                  state_q <= ST_ACK_SET;
                end
              endcase
            end else begin
              cnt_q <= cnt_q + 4'd1;
            end
          end
        end
        ST_ACK_SET: begin
          if (scl_fall) begin
            pull_q  <= 1'b1;
            state_q <= ST_ACK_HOLD;
          end
        end
        ST_ACK_HOLD: begin
          if (scl_fall) begin
            cnt_q <= '0;
            if (kind_q == BK_DEV && rw_q) begin
              tx_q    <= rd_data[DATA_W-2:0];
              pull_q  <= ~rd_data[DATA_W-1];
              state_q <= ST_TX;
            end else begin
              pull_q  <= 1'b0;
              kind_q  <= (kind_q == BK_DEV) ? BK_WADDR : BK_WDATA;
              state_q <= ST_RX;
            end
          end
        end
        ST_TX: begin
          if (scl_rise) begin
            cnt_q <= cnt_q + 4'd1;
          end else if (scl_fall) begin
            if (cnt_q == 4'd8) begin
              pull_q  <= 1'b0;
              state_q <= ST_MACK;
            end else begin
              pull_q <= ~tx_q[DATA_W-2];
              tx_q   <= {tx_q[DATA_W-3:0], 1'b0};
            end
          end
        end
        ST_MACK: begin
          if (scl_rise) begin
            addr_q  <= seq_step(addr_q);
            state_q <= sda_s ? ST_IDLE : ST_ACK_HOLD;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/twi_page_store.sv
module twi_page_store
  import twi_eeprom_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     buf_clr,
  input  logic                     buf_we,
  input  logic [PAGE_W-1:0]        buf_idx,
  input  logic [DATA_W-1:0]        buf_din,
  input  logic                     commit,
  input  logic                     wp,
  input  logic [ADDR_W-PAGE_W-1:0] page_sel,
  input  logic [ADDR_W-1:0]        rd_addr,
  output logic [DATA_W-1:0]        rd_data,
  output logic                     buf_any
);
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int PAGE_N = 1 << PAGE_W;

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [DATA_W-1:0] slot_data [PAGE_N];
  logic [PAGE_N-1:0] slot_valid;
  logic              mem_wr_en;

  genvar g;
  generate
    for (g = 0; g < PAGE_N; g++) begin : g_slot
      logic [DATA_W-1:0] data_q;
      logic              valid_q;
      logic              hit;
      assign hit = buf_we && (buf_idx == PAGE_W'(g));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          data_q  <= '0;
          valid_q <= 1'b0;
        end else begin
          if (hit) data_q <= buf_din;
          if (buf_clr || commit) valid_q <= 1'b0;
          else if (hit)          valid_q <= 1'b1;
        end
      end
      assign slot_data[g]  = data_q;
      assign slot_valid[g] = valid_q;
    end
  endgenerate

  assign buf_any   = |slot_valid;
  assign mem_wr_en = commit && !wp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (mem_wr_en) begin
      for (int i = 0; i < PAGE_N; i++) begin
        if (slot_valid[i]) mem_q[{page_sel, PAGE_W'(i)}] <= slot_data[i];
      end
    end
  end

  assign rd_data = mem_q[rd_addr];
endmodule

// File: rtl/twi_wr_timer.sv
module twi_wr_timer #(
  parameter int CYCLES = 625000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  localparam int CW = $clog2(CYCLES + 1);

  logic [CW-1:0] cnt_q;
  logic          busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (start) begin
      cnt_q  <= CW'(CYCLES - 1);
      busy_q <= 1'b1;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - CW'(1);
    end
  end

  assign busy = busy_q;
endmodule

// File: rtl/twi_eeprom_slave.sv
module twi_eeprom_slave
  import twi_eeprom_pkg::*;
#(
  parameter int WR_CYCLES = 625000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_i,
  input  logic               sda_i,
  input  logic [STRAP_W-1:0] strap_i,
  input  logic               wp_i,
  output logic               sda_pull_o
);
  logic                     sda_s, scl_rise, scl_fall, start_ev, stop_ev;
  logic                     busy, buf_any, buf_we, buf_clr, commit;
  logic [PAGE_W-1:0]        buf_idx;
  logic [DATA_W-1:0]        buf_din, rd_data;
  logic [ADDR_W-PAGE_W-1:0] page_sel;
  logic [ADDR_W-1:0]        rd_addr;

  twi_line_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev)
  );

  twi_proto_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_ev(start_ev), .stop_ev(stop_ev),
    .strap(strap_i), .busy(busy), .buf_any(buf_any), .rd_data(rd_data),
    .sda_pull(sda_pull_o), .buf_we(buf_we), .buf_idx(buf_idx),
    .buf_din(buf_din), .buf_clr(buf_clr), .commit(commit),
    .page_sel(page_sel), .rd_addr(rd_addr)
  );

  twi_page_store u_store (
    .clk(clk), .rst_n(rst_n), .buf_clr(buf_clr), .buf_we(buf_we),
    .buf_idx(buf_idx), .buf_din(buf_din), .commit(commit), .wp(wp_i),
    .page_sel(page_sel), .rd_addr(rd_addr), .rd_data(rd_data),
    .buf_any(buf_any)
  );

  twi_wr_timer #(.CYCLES(WR_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(commit), .busy(busy)
  );
endmodule

// File: rtl/twi_eeprom_checker.sv
module twi_eeprom_checker (
  input logic clk,
  input logic rst_n,
  input logic sda_pull_o,
  input logic scl_fall,
  input logic start_ev,
  input logic stop_ev,
  input logic commit,
  input logic busy
);
  // R1: a STOP always leaves the data line released
  a_r1_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> !sda_pull_o);

  // R4: array commit happens only in a STOP cycle
  a_r4_commit_at_stop: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> stop_ev);

  // R7: nothing is driven during the write cycle
  a_r7_quiet_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !sda_pull_o);

  // R7: a write cycle begins only from a commit
  a_r7_busy_from_commit: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(commit));

  // R8: the pull enable moves only after an SCL fall, START or STOP
  a_r8_pull_moves_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_pull_o) |-> ($past(scl_fall) || $past(start_ev) || $past(stop_ev)));
endmodule

bind twi_eeprom_slave twi_eeprom_checker u_chk (
  .clk(clk), .rst_n(rst_n), .sda_pull_o(sda_pull_o), .scl_fall(scl_fall),
  .start_ev(start_ev), .stop_ev(stop_ev), .commit(commit), .busy(busy)
);

// File: tb/tb_twi_eeprom_slave.sv
module tb_twi_eeprom_slave;
  localparam int WRC = 300;
  localparam int H   = 8;
  localparam logic [2:0] STRAP = 3'b101;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic wp = 1'b0;
  logic sda_pull;
  logic line;

  assign line = sda_m & ~sda_pull;

  twi_eeprom_slave #(.WR_CYCLES(WRC)) dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(line),
    .strap_i(STRAP), .wp_i(wp), .sda_pull_o(sda_pull)
  );

  always #4 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  int mon_err = 0;
  int exp_mem [256];
  int ptr = 0;
  int wq[$];
  bit finished = 1'b0;

  // per-clock comparison: the slave may not move SDA while SCL stays high (R8)
  logic prev_scl = 1'b1;
  logic prev_pull = 1'b0;
  always @(negedge clk) begin
    if (rst_n && scl_m && prev_scl && (sda_pull !== prev_pull)) mon_err++;
    prev_scl  = scl_m;
    prev_pull = sda_pull;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] dev(input bit rd);
    return {4'b1011, STRAP, rd};
  endfunction

  task automatic bus_start();
    sda_m = 1'b1;
    tick(H);
    if (!scl_m) begin
      scl_m = 1'b1;
      tick(H);
    end
    sda_m = 1'b0;
    tick(H);
    scl_m = 1'b0;
  endtask

  task automatic bus_stop();
    tick(2);
    sda_m = 1'b0;
    tick(H);
    scl_m = 1'b1;
    tick(H);
    sda_m = 1'b1;
    tick(H);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      tick(2);
      sda_m = b[i];
      tick(H - 2);
      scl_m = 1'b1;
      tick(H);
      scl_m = 1'b0;
    end
    tick(2);
    sda_m = 1'b1;
    tick(H - 2);
    scl_m = 1'b1;
    tick(H / 2);
    ack = !line;
    tick(H / 2);
    scl_m = 1'b0;
  endtask

  task automatic recv_byte(input bit give_ack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      tick(H);
      scl_m = 1'b1;
      tick(H / 2);
      b[i] = line;
      tick(H / 2);
      scl_m = 1'b0;
    end
    tick(2);
    sda_m = give_ack ? 1'b0 : 1'b1;
    tick(H - 2);
    scl_m = 1'b1;
    tick(H);
    scl_m = 1'b0;
    tick(2);
    sda_m = 1'b1;
  endtask

  task automatic poll(input bit expect_ack, input string req);
    bit a;
    bus_start();
    send_byte(dev(1'b0), a);
    chk(a == expect_ack, req, a, expect_ack);
    bus_stop();
  endtask

  task automatic write_seq(input int wa);
    bit a;
    int p;
    int pa[$];
    int pd[$];
    bus_start();
    send_byte(dev(1'b0), a);
    chk(a, "R2", a, 1);
    send_byte(wa[7:0], a);
    chk(a, "R3", a, 1);
    p = wa;
    foreach (wq[i]) begin
      send_byte(wq[i][7:0], a);
      chk(a, "R3", a, 1);
      pa.push_back(p);
      pd.push_back(wq[i]);
      p = (p & 'hF0) | ((p + 1) & 'h0F);
    end
    bus_stop();
    ptr = p;
    if (!wp) foreach (pa[i]) exp_mem[pa[i]] = pd[i];
  endtask

  task automatic read_seq(input bit set_addr, input int wa, input int n, input string req);
    bit a;
    logic [7:0] b;
    if (set_addr) begin
      bus_start();
      send_byte(dev(1'b0), a);
      chk(a, "R2", a, 1);
      send_byte(wa[7:0], a);
      chk(a, "R3", a, 1);
      ptr = wa;
    end
    bus_start();
    send_byte(dev(1'b1), a);
    chk(a, "R2", a, 1);
    for (int i = 0; i < n; i++) begin
      recv_byte(i < n - 1, b);
      chk(b == exp_mem[ptr][7:0], req, b, exp_mem[ptr]);
      ptr = (ptr + 1) & 255;
    end
    chk(sda_pull == 1'b0, "R9", sda_pull, 0);
    bus_stop();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    finish_run();
  end

  initial begin
    bit a;
    for (int i = 0; i < 256; i++) exp_mem[i] = 0;
    tick(5);
    rst_n = 1'b1;
    tick(5);
    chk(sda_pull == 1'b0, "R11", sda_pull, 0);

    // R2: prefix and strap mismatches, then a match
    bus_start();
    send_byte({4'b1010, STRAP, 1'b0}, a);
    chk(!a, "R2", a, 0);
    bus_stop();
    bus_start();
    send_byte({4'b1011, 3'b001, 1'b0}, a);
    chk(!a, "R2", a, 0);
    bus_stop();
    poll(1'b1, "R2");

    // R1: STOP in the middle of an address byte, then a clean restart
    bus_start();
    for (int i = 7; i >= 4; i--) begin
      tick(2);
      sda_m = dev(1'b0)[i];
      tick(H - 2);
      scl_m = 1'b1;
      tick(H);
      scl_m = 1'b0;
    end
    bus_stop();
    chk(sda_pull == 1'b0, "R1", sda_pull, 0);
    poll(1'b1, "R1");

    // R11 / R10: current-address read straight after reset
    read_seq(1'b0, 0, 1, "R11");

    // R3, R7, R4: single byte write, busy polling, read back
    wq = '{'hA5};
    write_seq('h10);
    poll(1'b0, "R7");
    tick(WRC + 40);
    poll(1'b1, "R7");
    read_seq(1'b1, 'h10, 1, "R4");

    // R4: page write wrapping inside the page
    wq = '{'h11, 'h22, 'h33, 'h44};
    write_seq('h2E);
    tick(WRC + 40);
    read_seq(1'b1, 'h20, 16, "R4");

    // R5: repeated START discards buffered data
    bus_start();
    send_byte(dev(1'b0), a);
    chk(a, "R2", a, 1);
    send_byte(8'h40, a);
    chk(a, "R3", a, 1);
    send_byte(8'h77, a);
    chk(a, "R3", a, 1);
    ptr = 'h41;
    read_seq(1'b0, 0, 1, "R5");
    poll(1'b1, "R5");
    read_seq(1'b1, 'h40, 1, "R5");

    // R9: sequential read across the top of the array; R10 resume point
    wq = '{'h01, 'h02};
    write_seq('hFE);
    tick(WRC + 40);
    wq = '{'h03};
    write_seq('h00);
    tick(WRC + 40);
    read_seq(1'b1, 'hFE, 3, "R9");
    read_seq(1'b0, 0, 1, "R10");

    // R6: write protect blocks the array update
    wp = 1'b1;
    wq = '{'h5A};
    write_seq('h10);
    tick(WRC + 40);
    wp = 1'b0;
    read_seq(1'b1, 'h10, 1, "R6");

    chk(mon_err == 0, "R8", mon_err, 0);
    finish_run();
  end
endmodule